// File: doc/BRIEF.md
# Banked Set-Associative Cache Read Lookup

This block is the read-lookup engine of a banked, eight-way set-associative cache. A 64-bit request address is split into a byte offset inside the line, a bank number, a set number inside that bank and a tag. Only the addressed bank drives its read outputs. The set's eight valid bits and eight stored tags are compared with the request tag in parallel, and the comparison yields a one-hot way-hit vector.

On a hit, the requested byte comes out through three selection stages. The first stage picks the hitting way's line, the second picks the 8-byte word and the third picks the byte. On a miss, the block raises a request to the next memory level, carrying the line-aligned address. A fill port writes a whole line, its tag and a set valid bit into a named bank, set and way. Choosing the way to fill is left to the caller.

Top module: `cache_lookup`

## Requirements
- R1: With the default geometry, request address bits [6:0] are the byte offset, bits [9:7] are the bank number, bits [11:10] are the set inside the bank, and bits [63:12] are the tag.
- R2: A synchronous reset clears every valid bit and the response registers. Any lookup after reset misses until a fill writes the line again.
- R3: A request is accepted on a rising edge where req_valid and req_ready are both high. resp_valid is high for exactly the one cycle after each accepted request, and is low otherwise.
- R4: A lookup hits only if some way of the addressed set is valid and its stored tag equals the request tag in every bit. A tag that differs in any single bit misses.
- R5: On a hit, resp_byte is line byte number offset. Within the line, the word is offset[6:3] and the byte inside the word is offset[2:0]. Line byte k is fill_line[8k+7:8k].
- R6: On a miss, miss_valid and resp_valid are high and resp_hit is low. miss_addr equals the request address with bits [6:0] cleared, and resp_byte is zero.
- R7: A fill writes the line, the tag and valid=1 into the given bank, set and way. A later fill of the same slot replaces the earlier content, so the old tag misses from then on.
- R8: Banks are independent. A line filled in one bank does not hit for an address that names another bank with the same set and tag.
- R9: req_ready is low in every cycle in which fill_valid is high. A request offered in such a cycle is not accepted and produces no response.
- R10: All eight ways of one set hold distinct lines at the same time. A lookup returns the data of whichever way holds the matching tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request can be accepted this cycle |
| req_addr | input | 64 | Byte address to look up |
| resp_valid | output | 1 | Response to the request accepted in the previous cycle |
| resp_hit | output | 1 | The response is a hit |
| resp_byte | output | 8 | Requested byte on a hit, zero otherwise |
| miss_valid | output | 1 | Request to the next memory level |
| miss_addr | output | 64 | Line-aligned address of the missing line |
| fill_valid | input | 1 | Write a line this cycle |
| fill_bank | input | 3 | Bank to write |
| fill_set | input | 2 | Set inside the bank to write |
| fill_way | input | 3 | Way to write |
| fill_tag | input | 52 | Tag stored with the line |
| fill_line | input | 1024 | Line data, byte k in bits [8k+7:8k] |

## Verification
The bench flips the lowest and the highest tag bit on their own. A comparator that ignored either bit would report a hit where a miss belongs. It reads the first byte, the last byte and one byte deep in the middle of a line, so a word or byte selector with swapped or shifted fields returns a wrong value. It fills all eight ways of one set, and reuses one set and tag in a second bank, so a faulty way mux or a bank that answers when not selected gives a wrong byte or a false hit. Refill, reset after fills, fill-time stalls and back-to-back requests show whether stale valid bits, a missing stall or a dropped response remain.

// File: rtl/cache_lookup_pkg.sv
package cache_lookup_pkg;
    parameter int unsigned ADDR_W        = 64;
    parameter int unsigned NUM_BANKS     = 8;
    parameter int unsigned SETS_PER_BANK = 4;
    parameter int unsigned NUM_WAYS      = 8;
    parameter int unsigned LINE_BYTES    = 128;
    parameter int unsigned WORD_BYTES    = 8;

    localparam int unsigned OFF_W    = $clog2(LINE_BYTES);
    localparam int unsigned BANK_W   = $clog2(NUM_BANKS);
    localparam int unsigned SET_W    = $clog2(SETS_PER_BANK);
    localparam int unsigned WAY_W    = $clog2(NUM_WAYS);
    localparam int unsigned TAG_W    = ADDR_W - OFF_W - BANK_W - SET_W;
    localparam int unsigned LINE_W   = LINE_BYTES * 8;
    localparam int unsigned WORD_W   = WORD_BYTES * 8;
    localparam int unsigned WSEL_W   = $clog2(LINE_BYTES / WORD_BYTES);
    localparam int unsigned BSEL_W   = $clog2(WORD_BYTES);
    localparam int unsigned LIDX_W   = $clog2(LINE_W);
    localparam int unsigned WIDX_W   = $clog2(WORD_W);

    typedef struct packed {
        logic              vld;
        logic              hit;
        logic [7:0]        data;
        logic              miss;
        logic [ADDR_W-1:0] maddr;
    } resp_t;
endpackage

// File: rtl/cache_bank.sv
module cache_bank
    import cache_lookup_pkg::*;
#(
    parameter int unsigned BANK_ID = 0
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               sel,
    input  logic [SET_W-1:0]                   set_idx,
    input  logic                               fill_en,
    input  logic [SET_W-1:0]                   fill_set,
    input  logic [WAY_W-1:0]                   fill_way,
    input  logic [TAG_W-1:0]                   fill_tag,
    input  logic [LINE_W-1:0]                  fill_line,
    output logic [NUM_WAYS-1:0]                rd_valid,
    output logic [NUM_WAYS-1:0][TAG_W-1:0]     rd_tags,
    output logic [NUM_WAYS-1:0][LINE_W-1:0]    rd_lines
);
    logic [NUM_WAYS-1:0] valid_q [SETS_PER_BANK];
    logic [TAG_W-1:0]    tag_q   [SETS_PER_BANK][NUM_WAYS];
    logic [LINE_W-1:0]   line_q  [SETS_PER_BANK][NUM_WAYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS_PER_BANK; s++) valid_q[s] <= '0;
        end else if (fill_en) begin
            valid_q[fill_set][fill_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_set][fill_way]  <= fill_tag;
            line_q[fill_set][fill_way] <= fill_line;
        end
    end

    // Unselected bank keeps its read outputs at zero.
    always_comb begin
        for (int w = 0; w < NUM_WAYS; w++) begin
            rd_valid[w] = sel & valid_q[set_idx][w];
            rd_tags[w]  = sel ? tag_q[set_idx][w]  : '0;
            rd_lines[w] = sel ? line_q[set_idx][w] : '0;
        end
    end
endmodule

// File: rtl/way_compare.sv
module way_compare
    import cache_lookup_pkg::*;
(
    input  logic [NUM_WAYS-1:0]            valid,
    input  logic [NUM_WAYS-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]               req_tag,
    output logic [NUM_WAYS-1:0]            way_hit
);
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        logic [TAG_W-1:0] diff;
        assign diff       = tags[w] ^ req_tag;
        assign way_hit[w] = valid[w] & ~(|diff);
    end
endmodule

// File: rtl/data_select.sv
module data_select
    import cache_lookup_pkg::*;
(
    input  logic [NUM_WAYS-1:0]             way_hit,
    input  logic [NUM_WAYS-1:0][LINE_W-1:0] lines,
    input  logic [WSEL_W-1:0]               word_sel,
    input  logic [BSEL_W-1:0]               byte_sel,
    output logic [7:0]                      sel_byte
);
    logic [LINE_W-1:0] line_sel;
    logic [WORD_W-1:0] word_sel_data;
    logic [LIDX_W-1:0] word_base;
    logic [WIDX_W-1:0] byte_base;

    // Stage 1: AND-OR over the one-hot hit vector, zero when no way hits.
    always_comb begin
        line_sel = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            line_sel = line_sel | (lines[w] & {LINE_W{way_hit[w]}});
        end
    end

    // Stage 2 and 3: word inside the line, then byte inside the word.
    assign word_base     = {word_sel, {WIDX_W{1'b0}}};
    assign word_sel_data = line_sel[word_base +: WORD_W];
    assign byte_base     = {byte_sel, 3'b000};
    assign sel_byte      = word_sel_data[byte_base +: 8];
endmodule

// File: rtl/cache_lookup.sv
module cache_lookup
    import cache_lookup_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic                 resp_valid,
    output logic                 resp_hit,
    output logic [7:0]           resp_byte,
    output logic                 miss_valid,
    output logic [ADDR_W-1:0]    miss_addr,
    input  logic                 fill_valid,
    input  logic [BANK_W-1:0]    fill_bank,
    input  logic [SET_W-1:0]     fill_set,
    input  logic [WAY_W-1:0]     fill_way,
    input  logic [TAG_W-1:0]     fill_tag,
    input  logic [LINE_W-1:0]    fill_line
);
    logic [OFF_W-1:0]  req_off;
    logic [BANK_W-1:0] req_bank;
    logic [SET_W-1:0]  req_set;
    logic [TAG_W-1:0]  req_tag;
    logic              accept;

    assign req_off   = req_addr[OFF_W-1:0];
    assign req_bank  = req_addr[OFF_W +: BANK_W];
    assign req_set   = req_addr[OFF_W+BANK_W +: SET_W];
    assign req_tag   = req_addr[ADDR_W-1 -: TAG_W];
    assign req_ready = ~fill_valid;
    assign accept    = req_valid & req_ready;

    logic [NUM_BANKS-1:0][NUM_WAYS-1:0]             bk_valid;
    logic [NUM_BANKS-1:0][NUM_WAYS-1:0][TAG_W-1:0]  bk_tags;
    logic [NUM_BANKS-1:0][NUM_WAYS-1:0][LINE_W-1:0] bk_lines;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic bank_sel;
        logic bank_fill;
        assign bank_sel  = accept & (req_bank == BANK_W'(b));
        assign bank_fill = fill_valid & (fill_bank == BANK_W'(b));
        cache_bank #(.BANK_ID(b)) u_bank (
            .clk       (clk),
            .rst       (rst),
            .sel       (bank_sel),
            .set_idx   (req_set),
            .fill_en   (bank_fill),
            .fill_set  (fill_set),
            .fill_way  (fill_way),
            .fill_tag  (fill_tag),
            .fill_line (fill_line),
            .rd_valid  (bk_valid[b]),
            .rd_tags   (bk_tags[b]),
            .rd_lines  (bk_lines[b])
        );
    end

    // Only the selected bank drives non-zero values, so OR merges them.
    logic [NUM_WAYS-1:0]             set_valid;
    logic [NUM_WAYS-1:0][TAG_W-1:0]  set_tags;
    logic [NUM_WAYS-1:0][LINE_W-1:0] set_lines;

    always_comb begin
        set_valid = '0;
        set_tags  = '0;
        set_lines = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            set_valid = set_valid | bk_valid[b];
            set_tags  = set_tags  | bk_tags[b];
            set_lines = set_lines | bk_lines[b];
        end
    end

    logic [NUM_WAYS-1:0] way_hit;
    logic [7:0]          sel_byte;

    way_compare u_cmp (
        .valid   (set_valid),
        .tags    (set_tags),
        .req_tag (req_tag),
        .way_hit (way_hit)
    );

    data_select u_sel (
        .way_hit  (way_hit),
        .lines    (set_lines),
        .word_sel (req_off[OFF_W-1 -: WSEL_W]),
        .byte_sel (req_off[BSEL_W-1:0]),
        .sel_byte (sel_byte)
    );

    resp_t r_d, r_q;

    always_comb begin
        r_d       = '0;
        r_d.vld   = accept;
        r_d.hit   = accept & (|way_hit);
        r_d.data  = accept ? sel_byte : 8'h00;
        r_d.miss  = accept & ~(|way_hit);
        r_d.maddr = r_d.miss ? {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}} : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign resp_valid = r_q.vld;
    assign resp_hit   = r_q.hit;
    assign resp_byte  = r_q.data;
    assign miss_valid = r_q.miss;
    assign miss_addr  = r_q.maddr;
endmodule

// File: rtl/cache_lookup_checker.sv
module cache_lookup_checker
    import cache_lookup_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic                req_ready,
    input logic                fill_valid,
    input logic                resp_valid,
    input logic                resp_hit,
    input logic [7:0]          resp_byte,
    input logic                miss_valid,
    input logic [ADDR_W-1:0]   miss_addr,
    input logic [NUM_WAYS-1:0] way_hit
);
    a_r3_resp_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> resp_valid);

    a_r3_no_unasked_resp: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_ready) |=> !resp_valid);

    a_r6_hit_or_miss: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> (resp_hit != miss_valid));

    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !resp_valid |-> (!resp_hit && !miss_valid));

    a_r6_miss_zero_aligned: assert property (@(posedge clk) disable iff (rst)
        miss_valid |-> (resp_byte == 8'h00 && miss_addr[OFF_W-1:0] == '0));

    a_r9_fill_stalls: assert property (@(posedge clk) disable iff (rst)
        fill_valid |-> !req_ready);

    a_r4_way_hit_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(way_hit));
endmodule

bind cache_lookup cache_lookup_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .fill_valid (fill_valid),
    .resp_valid (resp_valid),
    .resp_hit   (resp_hit),
    .resp_byte  (resp_byte),
    .miss_valid (miss_valid),
    .miss_addr  (miss_addr),
    .way_hit    (way_hit)
);

// File: tb/cache_lookup_bench.sv
module cache_lookup_bench;
    import cache_lookup_pkg::*;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                req_valid = 1'b0;
    logic                req_ready;
    logic [ADDR_W-1:0]   req_addr = '0;
    logic                resp_valid;
    logic                resp_hit;
    logic [7:0]          resp_byte;
    logic                miss_valid;
    logic [ADDR_W-1:0]   miss_addr;
    logic                fill_valid = 1'b0;
    logic [BANK_W-1:0]   fill_bank = '0;
    logic [SET_W-1:0]    fill_set = '0;
    logic [WAY_W-1:0]    fill_way = '0;
    logic [TAG_W-1:0]    fill_tag = '0;
    logic [LINE_W-1:0]   fill_line = '0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cache_lookup u_cache_lookup (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_byte(resp_byte), .miss_valid(miss_valid), .miss_addr(miss_addr),
        .fill_valid(fill_valid), .fill_bank(fill_bank), .fill_set(fill_set),
        .fill_way(fill_way), .fill_tag(fill_tag), .fill_line(fill_line)
    );

    function automatic logic [7:0] pat(int seed, int k);
        return 8'((seed * 37 + k * 7 + 1) & 255);
    endfunction

    function automatic logic [LINE_W-1:0] mk_line(int seed);
        logic [LINE_W-1:0] l;
        for (int k = 0; k < LINE_BYTES; k++) l[8*k +: 8] = pat(seed, k);
        return l;
    endfunction

    // R1 field layout: tag | set | bank | offset
    function automatic logic [ADDR_W-1:0] mk_addr(logic [TAG_W-1:0] t, int bank, int set, int off);
        return {t, SET_W'(set), BANK_W'(bank), OFF_W'(off)};
    endfunction

    task automatic chk(bit ok, string req, logic [ADDR_W-1:0] act, logic [ADDR_W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_fill(int bank, int set, int way, logic [TAG_W-1:0] t, int seed);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_bank = BANK_W'(bank);
        fill_set = SET_W'(set);
        fill_way = WAY_W'(way);
        fill_tag = t;
        fill_line = mk_line(seed);
        @(posedge clk);
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    // Offers one request, samples the response at the next falling edge.
    task automatic lookup(logic [ADDR_W-1:0] a);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_hit(string req, logic [ADDR_W-1:0] a, logic [7:0] b);
        lookup(a);
        chk(resp_valid && resp_hit && !miss_valid, req, {61'b0, resp_valid, resp_hit, miss_valid}, 64'b110);
        chk(resp_byte == b, req, 64'(resp_byte), 64'(b));
    endtask

    task automatic expect_miss(string req, logic [ADDR_W-1:0] a);
        lookup(a);
        chk(resp_valid && !resp_hit && miss_valid, req, {61'b0, resp_valid, resp_hit, miss_valid}, 64'b101);
        chk(miss_addr == {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}}, req, miss_addr, {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}});
        chk(resp_byte == 8'h00, req, 64'(resp_byte), 64'h0);
    endtask

    localparam logic [TAG_W-1:0] TA = 52'h9_1234_5678_ABCD;

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(!resp_valid && !miss_valid && req_ready, "R2 reset state",
            {61'b0, resp_valid, miss_valid, req_ready}, 64'b001);
        expect_miss("R2 empty after reset", mk_addr(TA, 3, 2, 0));
    endtask

    task automatic t_basic_hit();
        do_fill(3, 2, 5, TA, 11);
        expect_hit("R5 byte 0", mk_addr(TA, 3, 2, 0), pat(11, 0));
        expect_hit("R5 last byte", mk_addr(TA, 3, 2, 127), pat(11, 127));
        expect_hit("R5 word 9 byte 5", mk_addr(TA, 3, 2, 'h4D), pat(11, 'h4D));
        expect_hit("R1 offset 0x38", mk_addr(TA, 3, 2, 'h38), pat(11, 'h38));
        expect_miss("R1 other set", mk_addr(TA, 3, 1, 0));
    endtask

    task automatic t_tag_mismatch();
        expect_miss("R4 tag bit 0", mk_addr(TA ^ 52'h1, 3, 2, 5));
        expect_miss("R4 tag top bit", mk_addr(TA ^ (52'h1 << (TAG_W-1)), 3, 2, 77));
        expect_miss("R6 miss address", mk_addr(52'hF_0000_0000_0001, 6, 3, 99));
    endtask

    task automatic t_bank_isolation();
        expect_miss("R8 other bank", mk_addr(TA, 4, 2, 0));
        do_fill(4, 2, 5, TA, 23);
        expect_hit("R8 bank 4 own data", mk_addr(TA, 4, 2, 9), pat(23, 9));
        expect_hit("R8 bank 3 intact", mk_addr(TA, 3, 2, 9), pat(11, 9));
    endtask

    task automatic t_all_ways();
        for (int w = 0; w < NUM_WAYS; w++) do_fill(0, 1, w, TAG_W'(100 + w), 40 + w);
        for (int w = NUM_WAYS - 1; w >= 0; w--)
            expect_hit("R10 way data", mk_addr(TAG_W'(100 + w), 0, 1, 3 * w + 1), pat(40 + w, 3 * w + 1));
    endtask

    task automatic t_refill();
        do_fill(0, 1, 2, TAG_W'(555), 77);
        expect_miss("R7 old tag gone", mk_addr(TAG_W'(102), 0, 1, 0));
        expect_hit("R7 new line", mk_addr(TAG_W'(555), 0, 1, 64), pat(77, 64));
    endtask

    task automatic t_fill_stall();
        @(negedge clk);
        fill_valid = 1'b1;
        fill_bank = 3'd5;
        fill_set = 2'd0;
        fill_way = 3'd0;
        fill_tag = TAG_W'(9);
        fill_line = mk_line(5);
        req_valid = 1'b1;
        req_addr = mk_addr(TA, 3, 2, 0);
        #1;
        chk(!req_ready, "R9 ready low during fill", 64'(req_ready), 64'h0);
        @(posedge clk);
        @(negedge clk);
        fill_valid = 1'b0;
        req_valid = 1'b0;
        chk(!resp_valid, "R9 no response while stalled", 64'(resp_valid), 64'h0);
        expect_hit("R9 fill landed", mk_addr(TAG_W'(9), 5, 0, 1), pat(5, 1));
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        req_valid = 1'b1;
        req_addr = mk_addr(TA, 3, 2, 2);
        @(posedge clk);
        @(negedge clk);
        req_addr = mk_addr(TA ^ 52'h2, 3, 2, 2);
        chk(resp_valid && resp_hit && resp_byte == pat(11, 2), "R3 first of pair",
            64'(resp_byte), 64'(pat(11, 2)));
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(resp_valid && miss_valid, "R3 second of pair", {62'b0, resp_valid, miss_valid}, 64'b11);
        @(posedge clk);
        @(negedge clk);
        chk(!resp_valid, "R3 single cycle response", 64'(resp_valid), 64'h0);
    endtask

    task automatic t_reset_clears();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        expect_miss("R2 reset drops lines", mk_addr(TA, 3, 2, 0));
        expect_miss("R2 reset drops ways", mk_addr(TAG_W'(105), 0, 1, 0));
    endtask

    initial begin
        t_reset();
        t_basic_hit();
        t_tag_mismatch();
        t_bank_isolation();
        t_all_ways();
        t_refill();
        t_fill_stall();
        t_back_to_back();
        t_reset_clears();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule